// File: doc/BRIEF.md
# Programmable-flag offset register port

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full comparators use. It lets them be written and read back over the FIFO's own parallel buses. A load strobe, active low, redirects the write enable and the read enable away from the memory array and onto the two offset registers. A write loads the data bus into one register. A read places one register's value on the output bus.

The block keeps two single-bit pointers, one in each clock domain. The write pointer, clocked by the write clock, alternates each offset write between the empty register and the full register. The read pointer, clocked by the read clock, alternates offset reads in the same way. Either sequence may be interrupted by ordinary FIFO traffic or by idle cycles, and it resumes where it stopped. Only a master reset returns the pointers to the empty register.

The block also reports, for each flag, whether its offset is currently settled. The comparators downstream use these indications. The memory array and the comparators are not part of this block. Issuing an offset read and an offset write at the same time is outside the legal use and is not arbitrated.

Top module: `ofs_port`

## Requirements
- R1: While `mrst_n` is low, both pointers point to the empty register, `empty_ofs` and `full_ofs` hold their parameter defaults (127), `dout` is zero, and both `ae_ofs_valid` and `af_ofs_valid` are 1.
- R2: A write-clock edge with `load_n` = 0 and `wen_n` = 0 stores `din[14:0]` into the register selected by the write pointer and then moves the pointer to the other register. The order is empty, full, empty, and so on, and the other register is left unchanged.
- R3: A read-clock edge with `load_n` = 0 and `ren_n` = 0 places the selected register on `dout`, zero-extended so that bits 17:15 are 0, and moves the read pointer to the other register. The order is empty, full, empty, and so on.
- R4: The write pointer and the read pointer move independently: offset writes do not change which register the next offset read returns, and offset reads do not change which register the next offset write targets.
- R5: With `load_n` = 1, `fifo_we` equals the inverse of `wen_n`, and a write edge changes neither offset register nor the write pointer. Once `load_n` and `wen_n` are both low again, the write goes to the next register in the sequence.
- R6: A read edge on which `ren_n` or `load_n` is high does not move the read pointer. Once both are low again, the read sequence continues from the register after the last one read.
- R7: A read edge with `load_n` = 1 and `ren_n` = 0 places `fifo_q` on `dout` and raises `fifo_re`. A later offset read overwrites that word. With `ren_n` = 1, `dout` holds its value.
- R8: A read-clock edge with `prst_n` = 0 clears `dout` to zero and leaves both pointers and both offset registers unchanged.
- R9: `af_ofs_valid` is 0 from the first edge after a write to the empty register. It returns to 1 only after the full register has been written, two write-clock edges after that write.
- R10: `ae_ofs_valid` is 0 from the first edge after a write to the empty register, and returns to 1 two read-clock edges after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, synchronous to rd_clk, active low |
| load_n | input | 1 | Low selects the offset registers instead of the FIFO memory |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| din | input | 18 | Write data bus |
| fifo_q | input | 18 | Word read from the FIFO memory |
| dout | output | 18 | Registered output bus |
| empty_ofs | output | 15 | Almost-empty offset, to the comparator |
| full_ofs | output | 15 | Almost-full offset, to the comparator |
| fifo_we | output | 1 | Write strobe to the FIFO memory |
| fifo_re | output | 1 | Read strobe to the FIFO memory |
| ae_ofs_valid | output | 1 | Almost-empty offset is settled |
| af_ofs_valid | output | 1 | Almost-full offset is settled |

## Verification
The in-line assertions check on every cycle that:
- an offset write loads only the selected register from the low data bits;
- pointers and registers hold when no offset access is strobed;
- a partial reset clears the output bus;
- offset reads never drive the upper output bits;
- the almost-full indication drops right after the empty register is written.

Only the bench's scenarios can show the things that depend on a sequence of accesses: that the empty, full, empty order resumes correctly after interruptions by FIFO traffic and by partial reset, that the two pointers stay independent, that the settle windows last exactly two edges, and that a master reset in mid-sequence returns both pointers to the empty register.

// File: rtl/ofs_port.sv
module ofs_port #(
  parameter int DW = 18,
  parameter int OW = 15,
  parameter int AE_DEFAULT = 127,
  parameter int AF_DEFAULT = 127
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          load_n,
  input  logic          wen_n,
  input  logic          ren_n,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] fifo_q,
  output logic [DW-1:0] dout,
  output logic [OW-1:0] empty_ofs,
  output logic [OW-1:0] full_ofs,
  output logic          fifo_we,
  output logic          fifo_re,
  output logic          ae_ofs_valid,
  output logic          af_ofs_valid
);

  localparam logic [OW-1:0] AE_INIT = OW'(AE_DEFAULT);
  localparam logic [OW-1:0] AF_INIT = OW'(AF_DEFAULT);

  logic wptr, rptr;
  logic e_tok, f_tok, f_ok;
  logic f_s1, f_s2, e_s1, e_s2;
  logic unused_din;

  wire ofs_wr = ~load_n & ~wen_n;
  wire ofs_rd = ~load_n & ~ren_n;

  assign fifo_we    = load_n & ~wen_n;
  assign fifo_re    = load_n & ~ren_n;
  assign unused_din = ^din;

  // write domain: pointer, registers, validity tokens
  always_ff @(posedge wr_clk or negedge mrst_n) begin
    if (!mrst_n) begin
      wptr      <= 1'b0;
      empty_ofs <= AE_INIT;
      full_ofs  <= AF_INIT;
      e_tok     <= 1'b0;
      f_tok     <= 1'b0;
      f_ok      <= 1'b1;
      f_s1      <= 1'b0;
      f_s2      <= 1'b0;
    end else begin
      f_s1 <= f_tok;
      f_s2 <= f_s1;
      if (ofs_wr) begin
        wptr <= ~wptr;
        if (!wptr) begin
          empty_ofs <= din[OW-1:0];
          e_tok     <= ~e_tok;
          f_ok      <= 1'b0;
        end else begin
          full_ofs <= din[OW-1:0];
          f_tok    <= ~f_tok;
          f_ok     <= 1'b1;
        end
      end
    end
  end

  // read domain: pointer, output bus, almost-empty settle
  always_ff @(posedge rd_clk or negedge mrst_n) begin
    if (!mrst_n) begin
      rptr <= 1'b0;
      dout <= '0;
      e_s1 <= 1'b0;
      e_s2 <= 1'b0;
    end else begin
      e_s1 <= e_tok;
      e_s2 <= e_s1;
      if (ofs_rd) rptr <= ~rptr;
      if (!prst_n)      dout <= '0;
      else if (ofs_rd)  dout <= DW'(rptr ? full_ofs : empty_ofs);
      else if (!ren_n)  dout <= fifo_q;
    end
  end

  assign af_ofs_valid = f_ok & (f_s2 == f_tok);
  assign ae_ofs_valid = (e_s2 == e_tok);

  p_load_empty_r2: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    (ofs_wr && !wptr) |=> (empty_ofs == $past(din[OW-1:0])) && $stable(full_ofs));
  p_load_full_r2: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    (ofs_wr && wptr) |=> (full_ofs == $past(din[OW-1:0])) && $stable(empty_ofs));
  p_wr_hold_r5: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    !ofs_wr |=> $stable(wptr) && $stable(empty_ofs) && $stable(full_ofs));
  p_af_drop_r9: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    (ofs_wr && !wptr) |=> !af_ofs_valid);
  p_rd_hold_r6: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    !ofs_rd |=> $stable(rptr));
  p_hi_zero_r3: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    (ofs_rd && prst_n) |=> ((dout >> OW) == '0));
  p_prst_clr_r8: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    !prst_n |=> (dout == '0));

endmodule

// File: tb/test_ofs_port.sv
module test_ofs_port;
  logic clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, load_n = 1'b1, wen_n = 1'b1, ren_n = 1'b1;
  logic [17:0] din = '0, fifo_q = '0;
  logic [17:0] dout;
  logic [14:0] empty_ofs, full_ofs;
  logic fifo_we, fifo_re, ae_ofs_valid, af_ofs_valid;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [14:0] e_m = 15'd127, f_m = 15'd127;
  bit wp = 0, rp = 0;
  logic [17:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  ofs_port i_ofs_port (
    .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .load_n(load_n), .wen_n(wen_n), .ren_n(ren_n), .din(din), .fifo_q(fifo_q),
    .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .fifo_we(fifo_we), .fifo_re(fifo_re),
    .ae_ofs_valid(ae_ofs_valid), .af_ofs_valid(af_ofs_valid));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic l, input logic w, input logic r);
    load_n = l; wen_n = w; ren_n = r;
  endtask

  task automatic idle(input int n);
    drive(1, 1, 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ofs_write(input logic [17:0] v);
    drive(0, 0, 1); din = v;
    @(negedge clk);
    if (!wp) e_m = v[14:0]; else f_m = v[14:0];
    wp = ~wp;
    chk(empty_ofs == e_m && full_ofs == f_m, "R2 offset regs", {empty_ofs, 2'b0}, {e_m, 2'b0});
  endtask

  task automatic ofs_read();
    drive(0, 1, 0);
    exp_q.push_back(18'(rp ? f_m : e_m)); tag_q.push_back("R3 R4 R6 offset read");
    rp = ~rp;
    @(negedge clk);
  endtask

  task automatic fifo_read(input logic [17:0] v);
    drive(1, 1, 0); fifo_q = v;
    exp_q.push_back(v); tag_q.push_back("R7 fifo read");
    #1 chk(fifo_re == 1'b1, "R7 fifo_re", 32'(fifo_re), 1);
    @(negedge clk);
  endtask

  task automatic fifo_write(input logic [17:0] v);
    drive(1, 0, 1); din = v;
    #1 chk(fifo_we == 1'b1, "R5 fifo_we", 32'(fifo_we), 1);
    @(negedge clk);
    chk(empty_ofs == e_m && full_ofs == f_m, "R5 offsets kept", {empty_ofs, full_ofs}, {e_m, f_m});
  endtask

  // scoreboard monitor
  initial forever begin
    @(posedge clk);
    if (!ren_n && prst_n && mrst_n) begin
      @(negedge clk);
      if (exp_q.size() == 0) chk(0, "R3 unexpected read", 32'(dout), 0);
      else begin
        logic [17:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(dout == e, t, 32'(dout), 32'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dout == 0, "R1 dout", 32'(dout), 0);
    chk(empty_ofs == 127 && full_ofs == 127, "R1 defaults", {empty_ofs, full_ofs}, {15'd127, 15'd127});
    chk(ae_ofs_valid && af_ofs_valid, "R1 valid", {ae_ofs_valid, af_ofs_valid}, 3);
    mrst_n = 1'b1;
    idle(2);

    // R2 R9 R10: empty write starts programming
    ofs_write(18'h30005);
    chk(empty_ofs == 15'h0005, "R2 low bits", 32'(empty_ofs), 5);
    chk(!af_ofs_valid, "R9 af drop", 32'(af_ofs_valid), 0);
    chk(!ae_ofs_valid, "R10 ae drop", 32'(ae_ofs_valid), 0);
    idle(1);
    chk(!ae_ofs_valid, "R10 ae one edge", 32'(ae_ofs_valid), 0);
    idle(1);
    chk(ae_ofs_valid, "R10 ae two edges", 32'(ae_ofs_valid), 1);
    chk(!af_ofs_valid, "R9 af waits full", 32'(af_ofs_valid), 0);
    ofs_write(18'h01F00);
    chk(!af_ofs_valid, "R9 af at write", 32'(af_ofs_valid), 0);
    idle(1);
    chk(!af_ofs_valid, "R9 af one edge", 32'(af_ofs_valid), 0);
    idle(1);
    chk(af_ofs_valid, "R9 af two edges", 32'(af_ofs_valid), 1);
    ofs_write(18'h00011);
    chk(full_ofs == 15'h1F00, "R2 third edge to empty", 32'(full_ofs), 32'h1F00);

    // R4: read pointer at empty while write pointer at full
    ofs_read();
    ofs_write(18'h02222);
    chk(full_ofs == 15'h2222, "R4 write after read", 32'(full_ofs), 32'h2222);
    idle(1);

    // R6 R7: pause with ren high, then fifo read, then resume
    ofs_read();
    idle(2);
    chk(dout == 18'h02222, "R7 dout holds", 32'(dout), 32'h2222);
    fifo_read(18'h2AAAA);
    drive(0, 1, 1); @(negedge clk);
    ofs_read();
    ofs_read();
    idle(1);

    // R5: fifo writes interleave offset writes
    fifo_write(18'h00123);
    ofs_write(18'h00444);
    fifo_write(18'h00321);
    ofs_write(18'h00555);
    chk(empty_ofs == 15'h0444 && full_ofs == 15'h0555, "R5 resume", {empty_ofs, full_ofs}, {15'h0444, 15'h0555});
    drive(0, 1, 1); @(negedge clk);
    chk(empty_ofs == 15'h0444, "R5 load only no write", 32'(empty_ofs), 32'h0444);

    // R8: partial reset
    ofs_read();
    idle(1);
    prst_n = 1'b0; @(negedge clk); prst_n = 1'b1;
    chk(dout == 0, "R8 dout clear", 32'(dout), 0);
    chk(empty_ofs == 15'h0444 && full_ofs == 15'h0555, "R8 offsets kept", {empty_ofs, full_ofs}, {15'h0444, 15'h0555});
    ofs_read();
    ofs_write(18'h00666);
    idle(1);

    // R1: master reset mid-sequence
    mrst_n = 1'b0; @(negedge clk); mrst_n = 1'b1;
    e_m = 15'd127; f_m = 15'd127; wp = 0; rp = 0;
    chk(dout == 0 && empty_ofs == 127 && full_ofs == 127, "R1 mid reset", {empty_ofs, full_ofs}, {15'd127, 15'd127});
    idle(1);
    ofs_write(18'h00777);
    ofs_read();
    ofs_read();
    idle(2);
    chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule